// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator with Per-Conversion Settling

This block turns the 1-bit stream of a sigma-delta modulator into signed multi-bit results. It uses a cascade of integrators that run at the sample strobe, followed by differentiators that run once per decimation window. The filter order is selectable as three or four. The window length comes from a 10-bit rate code, so the notch spacing can be set from the system side.

Two modes are available. In continuous mode the integrator and differentiator state is carried from one output to the next, so after the initial fill a result follows every window. In per-conversion mode the filter starts from empty for each conversion and emits one result after the full settling span of order × window samples, then empties itself again. Each result therefore depends only on its own conversion's samples, at the cost of an output rate that is lower by a factor equal to the order. Both modes have the same frequency response. A synchronous clear lets the host discard partial data after it changes the input or the configuration.

Top module: `sinc_decim`

## Requirements
- R1: During and right after reset, `valid` is 0 and `result` is 0.
- R2: A sample is taken only in a cycle where `strobe` is 1. Bit value 1 counts as +1 and bit value 0 counts as −1. `valid` stays 0 in every cycle that does not follow a strobe edge.
- R3: When `ord4` is 1 the response is the four-fold self-convolution of a boxcar of M ones. When `ord4` is 0 it is the three-fold self-convolution. The order N is 4 or 3 to match.
- R4: The window length M in samples is SPF × FS, with SPF defaulting to 64 (1024 × FS clocks at one strobe per 16 clocks). FS = 0 is handled as FS = 1.
- R5: In continuous mode (`single` = 0), the first result after a clear or reset appears at sample N·M. Further results follow every M samples.
- R6: In per-conversion mode (`single` = 1), a result appears every N·M samples. All state is emptied after each result, so each result depends only on the N·M samples of its own conversion.
- R7: `valid` is a one-cycle pulse in the cycle right after the strobe edge that takes the last sample of a window. `result` holds its value until the next pulse.
- R8: `result` is the OUT_W-bit slice, starting at bit OUT_SHIFT, of the exact two's-complement filter output. The internal width cannot overflow at FS = 1023 with order 4.
- R9: `clr` empties all state and restarts the sample count from zero. `valid` is 0 in the cycle after a clear, and the next result is due N·M samples later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all filter state |
| strobe | input | 1 | Sample-take enable |
| bit_in | input | 1 | Modulator bit |
| fs | input | FS_W | Rate code |
| ord4 | input | 1 | 1 selects order 4, 0 selects order 3 |
| single | input | 1 | 1 selects per-conversion settling |
| result | output | OUT_W | Signed filter result |
| valid | output | 1 | One-cycle result strobe |

## Verification
A result is registered once, at the strobe edge that takes the window's last sample, so it is due one clock after that edge. The bench drives each sample on a falling edge. It samples `valid` and `result` on the following falling edge, which is half a cycle after the registering edge. In that cycle the bench checks whether a result is due from its own sample count, which is reset on each clear. It also checks that idle cycles and the cycle after a clear carry no pulse. Expected values come from a direct FIR built from boxcar convolutions over the stored sample history, so they do not depend on the integrator–differentiator structure.

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int SPF       = 64,
  parameter int FS_W      = 10,
  parameter int OUT_W     = 24,
  parameter int OUT_SHIFT = 4*$clog2(SPF*((1<<FS_W)-1)+1)+1-OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    strobe,
  input  logic                    bit_in,
  input  logic [FS_W-1:0]         fs,
  input  logic                    ord4,
  input  logic                    single,
  output logic signed [OUT_W-1:0] result,
  output logic                    valid
);
  localparam int CNT_W = $clog2(SPF*((1<<FS_W)-1)+1);
  localparam int ACC_W = 4*CNT_W+1;

  logic signed [ACC_W-1:0] integ [4];
  logic signed [ACC_W-1:0] dly   [4];
  logic signed [ACC_W-1:0] sum   [5];
  logic signed [ACC_W-1:0] dif   [5];
  logic signed [ACC_W-1:0] fir_out;
  logic [CNT_W-1:0] cnt, win_len;
  logic [FS_W-1:0]  fs_eff;
  logic [1:0]       ncomb;
  logic             win_end, settled;

  assign fs_eff  = (fs == '0) ? FS_W'(1) : fs;
  assign win_len = CNT_W'(fs_eff) * CNT_W'(SPF);
  assign win_end = strobe && (cnt >= win_len - CNT_W'(1));
  assign settled = (ncomb == (ord4 ? 2'd3 : 2'd2));

  always_comb begin
    sum[0] = {{(ACC_W-1){~bit_in}}, 1'b1};
    for (int k = 0; k < 4; k++) sum[k+1] = integ[k] + sum[k];
    dif[0] = ord4 ? sum[4] : sum[3];
    for (int k = 0; k < 4; k++) dif[k+1] = dif[k] - dly[k];
    fir_out = ord4 ? dif[4] : dif[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      cnt    <= '0;
      ncomb  <= '0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clr || (win_end && single && settled)) begin
        for (int k = 0; k < 4; k++) begin
          integ[k] <= '0;
          dly[k]   <= '0;
        end
        cnt   <= '0;
        ncomb <= '0;
      end else if (strobe) begin
        for (int k = 0; k < 4; k++) integ[k] <= sum[k+1];
        cnt <= win_end ? '0 : cnt + CNT_W'(1);
        if (win_end) begin
          for (int k = 0; k < 4; k++) dly[k] <= dif[k];
          if (!settled) ncomb <= ncomb + 2'd1;
        end
      end
      if (!clr && win_end && settled) begin
        valid  <= 1'b1;
        result <= fir_out[OUT_SHIFT +: OUT_W];
      end
    end
  end
endmodule

module sinc_decim_chk #(
  parameter int SPF  = 64,
  parameter int FS_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic            strobe,
  input logic [FS_W-1:0] fs,
  input logic            ord4,
  input logic            single,
  input logic            valid
);
  int sc, win, nwin;
  logic seen, dirty, ord4_p, single_p;
  logic [FS_W-1:0] fs_p;

  assign win  = ((fs == '0) ? 1 : int'(fs)) * SPF;
  assign nwin = (ord4 ? 4 : 3) * win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc <= 0; seen <= 1'b0; dirty <= 1'b0;
      fs_p <= '0; ord4_p <= 1'b0; single_p <= 1'b0;
    end else begin
      fs_p <= fs; ord4_p <= ord4; single_p <= single;
      if (clr) begin
        sc <= 0; seen <= 1'b0; dirty <= 1'b0;
      end else begin
        if (fs != fs_p || ord4 != ord4_p || single != single_p) dirty <= 1'b1;
        if (valid) begin
          sc <= strobe ? 1 : 0;
          seen <= 1'b1;
        end else if (strobe) sc <= sc + 1;
      end
    end
  end

  assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(strobe) && !$past(clr)));
  assert_clear_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid);
  assert_first_result_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dirty && !seen) |-> (sc == nwin));
  assert_continuous_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dirty && seen && !single) |-> (sc == win));
  assert_conversion_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dirty && single) |-> (sc == nwin));
endmodule

bind sinc_decim sinc_decim_chk #(.SPF(SPF), .FS_W(FS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe), .fs(fs),
  .ord4(ord4), .single(single), .valid(valid)
);

// File: tb/test_sinc_decim.sv
module test_sinc_decim;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, strobe = 1'b0, bit_in = 1'b0, ord4 = 1'b0, single = 1'b0;
  logic [9:0] fs = '0;
  logic signed [23:0] result;
  logic valid;

  always #5 clk = ~clk;

  sinc_decim #(.SPF(4), .FS_W(10), .OUT_W(24), .OUT_SHIFT(0)) i_sinc_decim (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe), .bit_in(bit_in),
    .fs(fs), .ord4(ord4), .single(single), .result(result), .valid(valid)
  );

  int errors = 0, checks = 0;
  int k, m_len, n_ord, klen;
  int xh [0:511];
  longint h [0:127];
  logic signed [23:0] last_res;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic build_kernel();
    longint t [0:127];
    for (int i = 0; i < 128; i++) h[i] = 0;
    h[0] = 1; klen = 1;
    for (int s = 0; s < n_ord; s++) begin
      for (int i = 0; i < klen + m_len - 1; i++) begin
        t[i] = 0;
        for (int j = 0; j < m_len; j++) if (i - j >= 0 && i - j < klen) t[i] += h[i-j];
      end
      klen = klen + m_len - 1;
      for (int i = 0; i < klen; i++) h[i] = t[i];
    end
  endtask

  function automatic longint ref_out();
    longint y = 0;
    for (int j = 0; j < klen; j++) if (k - j >= 1) y += h[j] * xh[k-j];
    return y;
  endfunction

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(valid == 1'b0, "R9 valid after clear", valid, 0);
    k = 0;
  endtask

  task automatic feed(input bit b, input int gap);
    bit exp_v;
    longint y;
    logic signed [23:0] e;
    strobe = 1'b1; bit_in = b;
    @(negedge clk);
    strobe = 1'b0;
    k++; xh[k] = b ? 1 : -1;
    exp_v = single ? (k % (n_ord*m_len) == 0)
                   : (k >= n_ord*m_len && (k - n_ord*m_len) % m_len == 0);
    check(valid == exp_v, single ? "R6 result timing" : "R5 result timing", valid, exp_v);
    if (exp_v) begin
      y = ref_out(); e = y[23:0];
      check(result == e, ord4 ? "R3 R8 order-4 value" : "R3 R8 order-3 value", result, e);
      last_res = result;
    end else check(result == last_res, "R7 result held", result, last_res);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(valid == 1'b0, "R2 no pulse without strobe", valid, 0);
    end
  endtask

  task automatic run(input int f, input bit o4, input bit sg, input int pat);
    int n;
    @(negedge clk);
    fs = 10'(f); ord4 = o4; single = sg;
    m_len = 4 * ((f == 0) ? 1 : f);   // R4 window length
    n_ord = o4 ? 4 : 3;
    build_kernel();
    do_clear();
    n = sg ? (2*n_ord*m_len + n_ord*m_len/2) : (n_ord*m_len + 2*m_len + m_len/2);
    for (int i = 0; i < n; i++) begin
      bit b;
      case (pat)
        0: b = 1'b1;
        1: b = (i % 3) != 0;
        2: begin b = lfsr[0]; lfsr = {lfsr[0]^lfsr[2]^lfsr[3]^lfsr[5], lfsr[15:1]}; end
        default: b = 1'b0;
      endcase
      feed(b, pat % 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 reset valid", valid, 0);
    check(result == 24'sd0, "R1 reset result", result, 0);
    rst_n = 1'b1;
    last_res = 0;
    @(negedge clk);
    check(valid == 1'b0 && result == 0, "R1 after reset", valid, 0);
    for (int f = 0; f <= 4; f++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 4; p++)
            run(f, o[0], s[0], p);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule